// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Processor

This block is a very small processor that runs a program held in the same word-addressed memory as its data. A program counter walks through consecutive memory words. Each 8-bit word is split into a command nibble and an operand address nibble. The processor then does one of five things: it empties its accumulator, copies a memory word into it, adds a memory word to it, writes it back to memory, or halts. An unknown command also halts the processor.

All memory traffic passes through an address register and a data register that sit in front of one single-port memory. The memory has an active-high read strobe and an active-low write strobe. Read data returns combinationally from the addressed cell. A write takes place at the clock edge while the write strobe is low. The surrounding system loads a program image while reset is held and releases reset. It then waits for the halt output and reads the results out of memory.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, and right after it is released, the program counter, the accumulator and the carry flag are zero and halted is low. No memory write is requested, and the first read after reset fetches address 0.
- R2: An instruction word carries its command in bits 7:4 and its operand address in bits 3:0. Instructions are fetched from consecutive addresses, and the program counter rises by one at each fetch.
- R3: Command 0000 (clear) sets the accumulator and the carry flag to zero. It takes 3 clock cycles, counting from the start of its fetch.
- R4: Command 1001 (load) drives the operand address onto mem_addr with mem_rd high, and places the word read there in the accumulator. The carry flag is left alone, and the instruction takes 4 cycles.
- R5: Command 1010 (add) reads the operand word into the data register on one edge. On the following edge it writes the sum into the accumulator, modulo 256, and the carry out of bit 7 into the carry flag. The instruction takes 5 cycles.
- R6: Command 1011 (store) pulls mem_wr_n low for exactly one cycle, with the operand address on mem_addr and the accumulator value on mem_wdata. It takes 4 cycles.
- R7: Command 1111, and any command other than 0000, 1001, 1010 and 1011, stops the processor. Halted rises 3 cycles after the fetch of that instruction begins. The program counter then holds the address after the stopping instruction, and no read or write is issued until reset.
- R8: mem_rd high and mem_wr_n low never occur in the same cycle.
- R9: The program clear, load a, add b, store c, stop, run with a = 2 and b = 3, leaves 5 in c and 5 in the accumulator, and halts after 19 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 4 | Memory address, driven from the address register |
| mem_rd | output | 1 | Memory read strobe, active high |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| mem_wdata | output | 8 | Write data, driven from the data register |
| mem_rdata | input | 8 | Read data from the addressed cell |
| acc_out | output | 8 | Accumulator value |
| carry_out | output | 1 | Carry flag from the last add |
| pc_out | output | 4 | Program counter |
| halted | output | 1 | High once a stopping command has executed |

## Verification
Several properties are checked on every cycle. The read and write strobes never overlap. A store drives the accumulator value as write data. The two-edge add leaves exactly the sum and carry of the operands it saw. A clear empties both the accumulator and the carry flag. A halted processor keeps its program counter and stays quiet on the bus. The per-instruction cycle counts, the decoding of undefined commands as stops, and the final memory contents after whole programs can only be shown by the bench. It runs directed and random programs against a bench-side instruction model and compares the results.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    // command field width is fixed by the instruction format
    localparam int CMD_W = 4;

    localparam logic [CMD_W-1:0] CMD_CLR  = 4'b0000;
    localparam logic [CMD_W-1:0] CMD_LOAD = 4'b1001;
    localparam logic [CMD_W-1:0] CMD_ADD  = 4'b1010;
    localparam logic [CMD_W-1:0] CMD_STOR = 4'b1011;
    localparam logic [CMD_W-1:0] CMD_STOP = 4'b1111;

    typedef enum logic [2:0] {
        PH_FETCH_A = 3'd0,   // program counter into address register
        PH_FETCH_R = 3'd1,   // read instruction word
        PH_DECODE  = 3'd2,   // split command / address
        PH_OPER    = 3'd3,   // operand memory access
        PH_SUM     = 3'd4,   // accumulator takes adder result
        PH_HALT    = 3'd5
    } phase_t;

    typedef struct packed {
        logic mar_pc;    // address register <- program counter
        logic mar_ir;    // address register <- operand field
        logic mdr_mem;   // data register <- memory read data
        logic mdr_acc;   // data register <- accumulator
        logic acc_clr;   // accumulator and carry <- 0
        logic acc_mem;   // accumulator <- memory read data
        logic acc_sum;   // accumulator and carry <- adder
        logic rd;        // memory read strobe
        logic wr;        // memory write request
    } ctl_t;

endpackage

// File: rtl/acc_cpu_adder.sv
module acc_cpu_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic [WIDTH:0] chain;

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic half;
        assign half         = a[i] ^ b[i];
        assign sum[i]       = half ^ chain[i];
        assign chain[i + 1] = (a[i] & b[i]) | (chain[i] & half);
    end

    assign cout = chain[WIDTH];

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CMD_W+ADDR_W-1:0]   rdata,
    output ctl_t                      ctl,
    output logic [ADDR_W-1:0]         pc,
    output logic [ADDR_W-1:0]         opnd_addr,
    output logic                      halted
);

    localparam int WORD_W = CMD_W + ADDR_W;

    typedef struct packed {
        phase_t              ph;
        logic [ADDR_W-1:0]   pc;
        logic [WORD_W-1:0]   ir;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [CMD_W-1:0] cmd;

    assign cmd = seq_q.ir[WORD_W-1 -: CMD_W];

    always_comb begin
        seq_d = seq_q;
        ctl   = '0;
        unique case (seq_q.ph)
            PH_FETCH_A: begin
                ctl.mar_pc = 1'b1;
                seq_d.ph   = PH_FETCH_R;
            end
            PH_FETCH_R: begin
                ctl.rd    = 1'b1;
                seq_d.ir  = rdata;
                seq_d.pc  = seq_q.pc + 1'b1;
                seq_d.ph  = PH_DECODE;
            end
            PH_DECODE: begin
                case (cmd)
                    CMD_CLR: begin
                        ctl.acc_clr = 1'b1;
                        seq_d.ph    = PH_FETCH_A;
                    end
                    CMD_LOAD, CMD_ADD: begin
                        ctl.mar_ir = 1'b1;
                        seq_d.ph   = PH_OPER;
                    end
                    CMD_STOR: begin
                        ctl.mar_ir  = 1'b1;
                        ctl.mdr_acc = 1'b1;
                        seq_d.ph    = PH_OPER;
                    end
                    default: seq_d.ph = PH_HALT;   // stop and undefined
                endcase
            end
            PH_OPER: begin
                case (cmd)
                    CMD_LOAD: begin
                        ctl.rd      = 1'b1;
                        ctl.acc_mem = 1'b1;
                        seq_d.ph    = PH_FETCH_A;
                    end
                    CMD_ADD: begin
                        ctl.rd      = 1'b1;
                        ctl.mdr_mem = 1'b1;
                        seq_d.ph    = PH_SUM;
                    end
                    CMD_STOR: begin
                        ctl.wr   = 1'b1;
                        seq_d.ph = PH_FETCH_A;
                    end
                    default: seq_d.ph = PH_HALT;
                endcase
            end
            PH_SUM: begin
                ctl.acc_sum = 1'b1;
                seq_d.ph    = PH_FETCH_A;
            end
            PH_HALT: seq_d = seq_q;
            default: seq_d.ph = PH_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.ph <= PH_FETCH_A;
            seq_q.pc <= '0;
            seq_q.ir <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pc        = seq_q.pc;
    assign opnd_addr = seq_q.ir[ADDR_W-1:0];
    assign halted    = (seq_q.ph == PH_HALT);

    // R7
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_HALT) |=> (seq_q.ph == PH_HALT) && $stable(seq_q.pc));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_FETCH_R) |=> (seq_q.pc == ADDR_W'($past(seq_q.pc) + 1'b1)));

endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  ctl_t                      ctl,
    input  logic [ADDR_W-1:0]         pc,
    input  logic [ADDR_W-1:0]         opnd_addr,
    input  logic [CMD_W+ADDR_W-1:0]   rdata,
    input  logic [CMD_W+ADDR_W-1:0]   sum,
    input  logic                      cout,
    output logic [ADDR_W-1:0]         mar,
    output logic [CMD_W+ADDR_W-1:0]   mdr,
    output logic [CMD_W+ADDR_W-1:0]   acc,
    output logic                      carry
);

    localparam int WORD_W = CMD_W + ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] mar;
        logic [WORD_W-1:0] mdr;
        logic [WORD_W-1:0] acc;
        logic              carry;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (ctl.mar_pc) regs_d.mar = pc;
        if (ctl.mar_ir) regs_d.mar = opnd_addr;
        if (ctl.mdr_mem) regs_d.mdr = rdata;
        if (ctl.mdr_acc) regs_d.mdr = regs_q.acc;
        if (ctl.acc_clr) begin
            regs_d.acc   = '0;
            regs_d.carry = 1'b0;
        end
        if (ctl.acc_mem) regs_d.acc = rdata;
        if (ctl.acc_sum) begin
            regs_d.acc   = sum;
            regs_d.carry = cout;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign mar   = regs_q.mar;
    assign mdr   = regs_q.mdr;
    assign acc   = regs_q.acc;
    assign carry = regs_q.carry;

    // R5
    add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.acc_sum |=> ({regs_q.carry, regs_q.acc} ==
                         $past({1'b0, regs_q.acc} + {1'b0, regs_q.mdr})));

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.acc_clr |=> (regs_q.acc == '0) && !regs_q.carry);

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic                       mem_rd,
    output logic                       mem_wr_n,
    output logic [CMD_W+ADDR_W-1:0]    mem_wdata,
    input  logic [CMD_W+ADDR_W-1:0]    mem_rdata,
    output logic [CMD_W+ADDR_W-1:0]    acc_out,
    output logic                       carry_out,
    output logic [ADDR_W-1:0]          pc_out,
    output logic                       halted
);

    localparam int WORD_W = CMD_W + ADDR_W;

    ctl_t              ctl;
    logic [ADDR_W-1:0] pc, opnd_addr, mar;
    logic [WORD_W-1:0] mdr, acc, sum;
    logic              carry, cout;

    acc_cpu_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdata     (mem_rdata),
        .ctl       (ctl),
        .pc        (pc),
        .opnd_addr (opnd_addr),
        .halted    (halted)
    );

    acc_cpu_adder #(.WIDTH(WORD_W)) u_add (
        .a    (acc),
        .b    (mdr),
        .sum  (sum),
        .cout (cout)
    );

    acc_cpu_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .pc        (pc),
        .opnd_addr (opnd_addr),
        .rdata     (mem_rdata),
        .sum       (sum),
        .cout      (cout),
        .mar       (mar),
        .mdr       (mdr),
        .acc       (acc),
        .carry     (carry)
    );

    assign mem_addr  = mar;
    assign mem_rd    = ctl.rd;
    assign mem_wr_n  = ~ctl.wr;
    assign mem_wdata = mdr;
    assign acc_out   = acc;
    assign carry_out = carry;
    assign pc_out    = pc;

    // R8
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && !mem_wr_n));

    // R6
    store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (mem_wdata == acc_out));

    // R7
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && mem_wr_n));

endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mem_addr;
    logic       mem_rd, mem_wr_n;
    logic [7:0] mem_wdata, mem_rdata;
    logic [7:0] acc_out;
    logic       carry_out;
    logic [3:0] pc_out;
    logic       halted;

    always #10 clk = ~clk;   // 50 MHz

    acc_cpu uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr_n(mem_wr_n), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc_out(acc_out), .carry_out(carry_out), .pc_out(pc_out), .halted(halted)
    );

    // memory model with a bench-side load port
    logic [7:0] mem [16];
    logic       ld_en = 1'b0;
    logic [3:0] ld_addr = '0;
    logic [7:0] ld_data = '0;

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (!mem_wr_n) mem[mem_addr] <= mem_wdata;
    end

    // bus monitor
    int   wr_cnt = 0, excl_err = 0, idle_err = 0;
    logic seen_first = 1'b0;
    logic [3:0] first_addr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            seen_first <= 1'b0;
        end else begin
            if (!mem_wr_n) wr_cnt <= wr_cnt + 1;
            if (mem_rd && !mem_wr_n) excl_err <= excl_err + 1;
            if (halted && (mem_rd || !mem_wr_n)) idle_err <= idle_err + 1;
            if (mem_rd && !seen_first) begin
                seen_first <= 1'b1;
                first_addr <= mem_addr;
            end
        end
    end

    int n_checks = 0, n_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // program image and reference model state
    logic [7:0] img  [16];
    logic [7:0] rmem [16];
    logic [7:0] r_acc;
    logic       r_carry;
    logic [3:0] r_pc;
    int         r_cyc, r_wr;

    task automatic model();
        bit stop = 1'b0;
        logic [7:0] w;
        logic [8:0] s;
        for (int i = 0; i < 16; i++) rmem[i] = img[i];
        r_acc = '0; r_carry = 1'b0; r_pc = '0; r_cyc = 0; r_wr = 0;
        for (int n = 0; n < 16 && !stop; n++) begin
            w    = rmem[r_pc];
            r_pc = r_pc + 4'd1;
            case (w[7:4])
                4'b0000: begin r_acc = '0; r_carry = 1'b0; r_cyc += 3; end
                4'b1001: begin r_acc = rmem[w[3:0]]; r_cyc += 4; end
                4'b1010: begin
                    s = {1'b0, r_acc} + {1'b0, rmem[w[3:0]]};
                    r_acc = s[7:0]; r_carry = s[8]; r_cyc += 5;
                end
                4'b1011: begin rmem[w[3:0]] = r_acc; r_wr++; r_cyc += 4; end
                default: begin r_cyc += 3; stop = 1'b1; end
            endcase
        end
    endtask

    task automatic run_image(input string tag);
        int cyc, w0, i0;
        bit done;
        logic [3:0] pc_h;
        rst_n = 1'b0;
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = 4'(a); ld_data = img[a];
        end
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(pc_out == 0 && acc_out == 0 && !carry_out && !halted && mem_wr_n,
            "R1", {tag, " reset state"}, {pc_out, acc_out, 3'b0, carry_out, 3'b0, halted},
            0);
        model();
        w0 = wr_cnt;
        rst_n = 1'b1;
        cyc = 0; done = 1'b0;
        while (!done && cyc < 400) begin
            @(posedge clk); cyc++; #1;
            if (halted) done = 1'b1;
        end
        chk(done, "R7", {tag, " halt reached"}, int'(done), 1);
        // R3 R4 R5 R6 per-command cycle counts, R7 stop latency
        chk(cyc == r_cyc, "R5", {tag, " cycles to halt"}, cyc, r_cyc);
        chk(acc_out == r_acc, "R4", {tag, " accumulator"}, acc_out, r_acc);
        chk(carry_out == r_carry, "R5", {tag, " carry"}, carry_out, r_carry);
        chk(pc_out == r_pc, "R2", {tag, " pc at halt"}, pc_out, r_pc);
        chk(first_addr == 0, "R1", {tag, " first fetch address"}, first_addr, 0);
        for (int a = 0; a < 16; a++)
            chk(mem[a] === rmem[a], "R6", {tag, " memory word"}, {a, mem[a]}, {a, rmem[a]});
        chk(wr_cnt - w0 == r_wr, "R6", {tag, " write strobes"}, wr_cnt - w0, r_wr);
        i0 = idle_err; pc_h = pc_out;
        repeat (4) @(posedge clk);
        #1;
        chk(idle_err == i0 && pc_out == pc_h && halted, "R7",
            {tag, " frozen after halt"}, {idle_err - i0, pc_out}, {0, pc_h});
        chk(excl_err == 0, "R8", {tag, " read/write overlap"}, excl_err, 0);
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        n_checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [7:0] undef_cmds [7];
        int seed_dummy;
        undef_cmds = '{8'h10, 8'h2C, 8'h37, 8'h41, 8'h5F, 8'hC3, 8'hE8};
        seed_dummy = $urandom(32'd1945);

        // R9 directed: clear, load a, add b, store c, stop
        for (int a = 0; a < 16; a++) img[a] = 8'h00;
        img[0] = 8'h00; img[1] = 8'h98; img[2] = 8'hA9; img[3] = 8'hBA; img[4] = 8'hF0;
        img[8] = 8'd2;  img[9] = 8'd3;
        run_image("R9 sum");
        chk(mem[10] == 8'd5, "R9", "c holds a+b", mem[10], 5);

        // R5 carry out of bit 7 with wrap
        img[0] = 8'h98; img[1] = 8'hA9; img[2] = 8'hBA; img[3] = 8'hF0;
        img[8] = 8'hFF; img[9] = 8'h01;
        run_image("R5 carry wrap");

        // R3 clear removes a pending carry
        img[0] = 8'h98; img[1] = 8'hA9; img[2] = 8'h00; img[3] = 8'hF7;
        img[8] = 8'hF0; img[9] = 8'h22;
        run_image("R3 clear after carry");

        // R7 undefined command as the very first word
        img[0] = 8'h30;
        run_image("R7 undefined first");

        // random programs
        for (int r = 0; r < 24; r++) begin
            int len;
            len = $urandom_range(1, 7);
            for (int a = 0; a < 16; a++) img[a] = 8'($urandom);
            for (int k = 0; k < len; k++) begin
                case ($urandom_range(0, 3))
                    0: img[k] = 8'h00;
                    1: img[k] = {4'b1001, 1'b1, 3'($urandom)};
                    2: img[k] = {4'b1010, 1'b1, 3'($urandom)};
                    default: img[k] = {4'b1011, 1'b1, 3'($urandom)};
                endcase
            end
            if ($urandom_range(0, 2) == 0) img[len] = undef_cmds[$urandom_range(0, 6)];
            else img[len] = {4'b1111, 4'($urandom)};
            run_image($sformatf("random %0d", r));
        end

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule